// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Hold-Off

This block keeps the program-counter values that a processor core must get back when it returns from subroutines and interrupt handlers. Software cannot read or write it. A subroutine call, or an interrupt that is acknowledged, writes the present program counter onto the stack. A return, or a return from an interrupt, takes the newest entry off the stack and presents it as the program counter to restore. The stack depth and the program-counter width are parameters.

The block also decides whether an interrupt is acknowledged. The core gives it one input that means an enabled interrupt is pending. The block acknowledges that interrupt only when a level is free and no call or return uses the stack in the same cycle. While every level is occupied, the request stays pending and is not acknowledged. The first return frees a level, and the interrupt is then taken.

A call made while the stack is full does not stall. It overwrites the oldest entry, so the stack always holds the newest entries, up to the depth.

Top module: `ras_top`

## Requirements
- R1: A synchronous active-high reset leaves the stack empty: `empty`=1, `full`=0, `ret_pc`=0.
- R2: A return after one or more calls presents the program counter of the newest unreturned push on `ret_pc` in the clock cycle after the return. Entries come back in last-in, first-out order.
- R3: `full` is 1 exactly when DEPTH entries are held, and `empty` is 1 exactly when none are held. Both flags change in the cycle after the push or pop that changes the count.
- R4: With a free level and neither `call_req` nor `ret_req` high, `irq_ack` follows `irq_req` combinationally. An acknowledge pushes `pc_in` just as a call does.
- R5: While `full` is 1, `irq_ack` stays 0 whatever `irq_req` is.
- R6: If an interrupt is held off by a full stack and a return then takes place, `irq_ack` rises in the next cycle when `irq_req` is still high.
- R7: A call while full drops the oldest entry. After DEPTH+1 calls into an empty stack, DEPTH returns give back the newest DEPTH addresses, newest first.
- R8: A return on an empty stack leaves `ret_pc` holding the last value it presented, and the stack stays empty.
- R9: When `call_req` and `ret_req` are both high, only the pop happens. The called address is not stored.
- R10: `irq_ack` is never 1 in a cycle in which `call_req` or `ret_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call_req | input | 1 | Subroutine call; push `pc_in` |
| ret_req | input | 1 | Return or return-from-interrupt; pop |
| irq_req | input | 1 | Enabled interrupt pending |
| pc_in | input | PC_W | Program counter to save |
| irq_ack | output | 1 | Interrupt acknowledged this cycle (pushes `pc_in`) |
| ret_pc | output | PC_W | Restored program counter, registered |
| full | output | 1 | All DEPTH levels hold entries |
| empty | output | 1 | No entries held |

## Verification
The hardest case to reach is an interrupt that is held back by a full stack and then released by a return. The stimulus fills all levels with calls and keeps `irq_req` high through a return. It then checks that the acknowledge appears in the very next cycle and that the interrupted address comes back at the top of the stack. Overflow is reached the same way: one call more than the depth, then enough returns to drain the stack and one more to exercise the empty-stack hold.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } ras_op_e;

    // Pop outranks push; an acknowledged interrupt pushes like a call.
    function automatic ras_op_e ras_decode(input logic call_i,
                                           input logic ack_i,
                                           input logic ret_i);
        if (ret_i)
            return OP_POP;
        else if (call_i || ack_i)
            return OP_PUSH;
        else
            return OP_IDLE;
    endfunction

endpackage

// File: rtl/ras_irq_gate.sv
module ras_irq_gate
    import ras_pkg::*;
(
    input  logic    irq_req,
    input  logic    call_req,
    input  logic    ret_req,
    input  logic    full,
    output logic    irq_ack,
    output ras_op_e op
);
    // Hold the interrupt while no level is free or the stack is busy.
    always_comb begin
        irq_ack = irq_req && !full && !call_req && !ret_req;
        op      = ras_decode(call_req, irq_ack, ret_req);
    end
endmodule

// File: rtl/ras_pointer.sv
module ras_pointer
    import ras_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ras_op_e              op,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [IDX_W-1:0]     rd_idx,
    output logic                 do_write,
    output logic                 do_read,
    output logic                 full,
    output logic                 empty
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DEPTH - 1);

    logic [CNT_W-1:0] count_q;
    logic [IDX_W-1:0] top_q;
    logic [IDX_W-1:0] top_inc;
    logic [IDX_W-1:0] top_dec;

    always_comb begin
        top_inc  = (top_q == IDX_MAX) ? '0 : top_q + 1'b1;
        top_dec  = (top_q == '0) ? IDX_MAX : top_q - 1'b1;
        full     = (count_q == CNT_MAX);
        empty    = (count_q == '0);
        wr_idx   = top_q;
        rd_idx   = top_dec;
        do_write = (op == OP_PUSH);
        do_read  = (op == OP_POP) && !empty;
    end

    // Circular ring: when full, the write slot is the oldest entry.
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            top_q   <= '0;
        end else if (do_write) begin
            top_q <= top_inc;
            if (!full)
                count_q <= count_q + 1'b1;
        end else if (do_read) begin
            top_q   <= top_dec;
            count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/ras_storage.sv
module ras_storage #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [PC_W-1:0]   wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [PC_W-1:0]   rdata
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PC_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(g)))
                slot[g] <= wdata;
        end
    end

    assign rdata = slot[ridx];
endmodule

// File: rtl/ras_top.sv
module ras_top
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PC_W  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            call_req,
    input  logic            ret_req,
    input  logic            irq_req,
    input  logic [PC_W-1:0] pc_in,
    output logic            irq_ack,
    output logic [PC_W-1:0] ret_pc,
    output logic            full,
    output logic            empty
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ras_op_e          op;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             do_write;
    logic             do_read;
    logic [PC_W-1:0]  rd_data;

    ras_irq_gate u_gate (
        .irq_req  (irq_req),
        .call_req (call_req),
        .ret_req  (ret_req),
        .full     (full),
        .irq_ack  (irq_ack),
        .op       (op)
    );

    ras_pointer #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .do_write (do_write),
        .do_read  (do_read),
        .full     (full),
        .empty    (empty)
    );

    ras_storage #(.DEPTH(DEPTH), .PC_W(PC_W)) u_mem (
        .clk   (clk),
        .we    (do_write),
        .widx  (wr_idx),
        .wdata (pc_in),
        .ridx  (rd_idx),
        .rdata (rd_data)
    );

    // Registered restore value; an empty pop leaves it untouched.
    always_ff @(posedge clk) begin
        if (rst)
            ret_pc <= '0;
        else if (do_read)
            ret_pc <= rd_data;
    end
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            call_req,
    input logic            ret_req,
    input logic            irq_req,
    input logic            irq_ack,
    input logic [PC_W-1:0] ret_pc,
    input logic            full,
    input logic            empty
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (empty && !full && ret_pc == '0));

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    assert_ack_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> irq_req);

    assert_full_blocks_ack_R5: assert property (@(posedge clk) disable iff (rst)
        full |-> !irq_ack);

    assert_ret_releases_R6: assert property (@(posedge clk) disable iff (rst)
        (full && ret_req) |=> !full);

    assert_empty_pop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (empty && ret_req) |=> ($stable(ret_pc) && empty));

    assert_ack_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (!call_req && !ret_req));
endmodule

bind ras_top ras_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .call_req (call_req),
    .ret_req  (ret_req),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .ret_pc   (ret_pc),
    .full     (full),
    .empty    (empty)
);

// File: tb/ras_top_tb_top.sv
module ras_top_tb_top;
    localparam int DEPTH = 8;
    localparam int PC_W  = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            call_req = 1'b0;
    logic            ret_req = 1'b0;
    logic            irq_req = 1'b0;
    logic [PC_W-1:0] pc_in = '0;
    logic            irq_ack;
    logic [PC_W-1:0] ret_pc;
    logic            full;
    logic            empty;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [PC_W-1:0] model[$];
    logic [PC_W-1:0] exp_q[$];
    string           tag_q[$];
    logic [PC_W-1:0] last_pop = '0;
    logic            ret_q = 1'b0;

    always #10 clk = ~clk;

    ras_top #(.DEPTH(DEPTH), .PC_W(PC_W)) dut_i (.*);

    task automatic check(input bit ok, input string req,
                         input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always_ff @(posedge clk) ret_q <= ret_req;

    // Monitor: restored PC is registered, so it is due one cycle after the return.
    initial begin
        forever begin
            @(negedge clk);
            if (ret_q && !rst) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", ret_pc, '0);
                end else begin
                    automatic logic [PC_W-1:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(ret_pc == e, t, ret_pc, e);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, checks combinational ack and the flags.
    task automatic step(input bit c, input bit r, input bit i,
                        input logic [PC_W-1:0] pc, input string tag);
        bit exp_ack;
        @(negedge clk);
        call_req = c; ret_req = r; irq_req = i; pc_in = pc;
        #1;
        exp_ack = i && !c && !r && (model.size() < DEPTH);
        check(irq_ack == exp_ack, tag, PC_W'(irq_ack), PC_W'(exp_ack));
        check(full == (model.size() == DEPTH), "R3", PC_W'(full), PC_W'(model.size() == DEPTH));
        check(empty == (model.size() == 0), "R3", PC_W'(empty), PC_W'(model.size() == 0));
        if (r) begin
            if (model.size() > 0) last_pop = model.pop_back();
            exp_q.push_back(last_pop);
            tag_q.push_back(tag);
        end else if (c || exp_ack) begin
            if (model.size() == DEPTH) void'(model.pop_front());
            model.push_back(pc);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, '0, "R4");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(empty == 1'b1, "R1", PC_W'(empty), 1);
        check(full == 1'b0, "R1", PC_W'(full), 0);
        check(ret_pc == '0, "R1", ret_pc, 0);

        // R2 LIFO order
        step(1, 0, 0, 16'h1111, "R2");
        step(1, 0, 0, 16'h2222, "R2");
        step(1, 0, 0, 16'h3333, "R2");
        for (int k = 0; k < 3; k++) step(0, 1, 0, '0, "R2");
        // R8 pop on empty holds the value
        step(0, 1, 0, '0, "R8");
        step(0, 1, 0, '0, "R8");
        idle(1);

        // R4 interrupt acknowledged on a free level, pushes pc_in
        step(0, 0, 1, 16'h4A4A, "R4");
        step(0, 1, 0, '0, "R4");
        // R10 irq together with call or return is not acknowledged
        step(1, 0, 1, 16'h5151, "R10");
        step(0, 1, 1, '0, "R10");
        idle(1);

        // R5 fill, interrupt held; R6 return releases it
        for (int k = 0; k < DEPTH; k++) step(1, 0, 0, PC_W'(16'h0A00 + k), "R3");
        step(0, 0, 1, 16'hBEEF, "R5");
        step(0, 0, 1, 16'hBEEF, "R5");
        step(0, 1, 1, '0, "R6");
        step(0, 0, 1, 16'hC0DE, "R6");
        step(0, 1, 0, '0, "R6");
        for (int k = 0; k < DEPTH - 1; k++) step(0, 1, 0, '0, "R2");
        idle(1);

        // R7 overflow drops the oldest entry
        for (int k = 0; k <= DEPTH; k++) step(1, 0, 0, PC_W'(16'h0100 + k), "R7");
        for (int k = 0; k < DEPTH; k++) step(0, 1, 0, '0, "R7");
        step(0, 1, 0, '0, "R8");
        idle(1);

        // R9 call with return: pop wins, call discarded
        step(1, 0, 0, 16'h7777, "R9");
        step(1, 1, 0, 16'h8888, "R9");
        step(0, 1, 0, '0, "R9");
        idle(2);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #4ms;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule